// File: doc/BRIEF.md
# Serial Result Output Port

This block is the device-side end of a read-only two-wire link that carries conversion results out of a converter. One output line does two jobs. While no word is waiting it rests high. It drops low to signal that a fresh result can be read. It then carries that word serially, one bit per falling edge of a serial clock that the host supplies. The serial clock is slow and asynchronous. It is brought into the fast system clock domain by a synchronizer, and both of its edges are detected there.

At each conversion-complete strobe, the sequencer delivers a 24-bit offset-binary result, an out-of-range flag and the current filter and gain selections. The port latches these and holds the line high for a short guard window, during which serial clock edges are ignored. It then loads the new word, which replaces any word that was unread or only partly read. A change of gain or filter settings, or power-down, cancels the word in progress. After a settings change the line is held high, so a read returns all ones. During power-down the line is released (tristated).

Top module: `serial_result_port`

## Requirements
- R1: A word is 32 bits long and is sent most significant bit first. Bits 31..8 carry the result. The status byte follows in this order: ready (always 0 in a delivered word), filter select, error flag, two identity bits 0 then 1, gain select, and two check bits 0 then 1.
- R2: The result field is passed through unchanged in offset binary. 0x000000, 0x800000 and 0xFFFFFF arrive exactly as supplied.
- R3: Once a word is loaded, the line reads 0 until the first falling edge of the serial clock.
- R4: The first falling edge of the serial clock presents bit 31. Each later falling edge presents the next lower bit. The serial clock may stay idle for any time in the middle of a word without any bit being lost.
- R5: After the 32nd falling edge, the rising edge that follows sends the line high. It stays high until the next load, so a word can be read only once.
- R6: A load strobe drives the line high for GUARD_CYC system cycles, and serial clock edges in that window are ignored. The new word then replaces any earlier word, and a partial read restarts from bit 31.
- R7: A settings-change strobe discards any pending or partly read word. The line then stays high, so clocking returns all ones, until the next load.
- R8: While power-down is asserted, the output enable is low one cycle later and all state is cleared. After release the line is enabled, reads high and offers no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| powerdown | input | 1 | Power-down; releases the line and clears state |
| cfg_change | input | 1 | One-cycle strobe: gain or filter setting changed |
| load_req | input | 1 | One-cycle conversion-complete strobe |
| res_data | input | RES_W | Offset-binary conversion result |
| res_err | input | 1 | Input was out of range during the conversion |
| cfg_filter | input | 1 | Filter selection reported in the status byte |
| cfg_gain | input | 1 | Gain selection reported in the status byte |
| sclk | input | 1 | Host serial clock, asynchronous |
| sdo | output | 1 | Combined ready flag and serial data |
| sdo_en | output | 1 | Output enable for the line; 0 means tristate |

## Verification
The hardest case to reach is a serial clock edge that lands inside the guard window. It must be swallowed, and the word loaded just after it must still start cleanly at bit 31. The bench reaches this by lowering the serial clock one system cycle after the load strobe and raising it again a cycle later. Because of the synchronizer delay, the edge arrives while the guard is still counting. The bench then reads a full word and compares it with the scoreboard entry. The partly-read-then-overwritten case and the settings-change case are driven the same way. The expected queue is flushed where the block must discard a word, and the expected value is all ones after a settings change.

// File: rtl/srp_pkg.sv
package srp_pkg;
    typedef enum logic [1:0] {
        M_IDLE  = 2'd0,
        M_GUARD = 2'd1,
        M_READY = 2'd2
    } mode_e;

    localparam int STAT_W = 8;
endpackage

// File: rtl/srp_sclk_sync.sv
module srp_sclk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    output logic fall_o,
    output logic rise_o
);
    logic [STAGES:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-1:0], sclk_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign fall_o = chain_q[STAGES] & ~chain_q[STAGES-1];
    assign rise_o = ~chain_q[STAGES] & chain_q[STAGES-1];
endmodule

// File: rtl/srp_word_pack.sv
module srp_word_pack
    import srp_pkg::*;
#(
    parameter int RES_W  = 24,
    localparam int WORD_W = RES_W + STAT_W
) (
    input  logic [RES_W-1:0]  res_i,
    input  logic              err_i,
    input  logic              filt_i,
    input  logic              gain_i,
    output logic [WORD_W-1:0] word_o
);
    logic [STAT_W-1:0] stat;

    // status order is fixed: ready, filter, error, id[1:0], gain, check[1:0]
    always_comb begin
        stat   = {1'b0, filt_i, err_i, 2'b01, gain_i, 2'b01};
        word_o = {res_i, stat};
    end
endmodule

// File: rtl/serial_result_port.sv
module serial_result_port
    import srp_pkg::*;
#(
    parameter int RES_W       = 24,
    parameter int GUARD_CYC   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             powerdown,
    input  logic             cfg_change,
    input  logic             load_req,
    input  logic [RES_W-1:0] res_data,
    input  logic             res_err,
    input  logic             cfg_filter,
    input  logic             cfg_gain,
    input  logic             sclk,
    output logic             sdo,
    output logic             sdo_en
);
    localparam int WORD_W = RES_W + STAT_W;
    localparam int CNT_W  = $clog2(WORD_W + 1);
    localparam int GRD_W  = $clog2(GUARD_CYC + 1);

    typedef struct packed {
        mode_e             mode;
        logic              live;
        logic [WORD_W-1:0] shreg;
        logic [WORD_W-1:0] pend;
        logic [CNT_W-1:0]  cnt;
        logic [GRD_W-1:0]  grd;
    } st_t;

    localparam st_t ST_RST = '{mode: M_IDLE, live: 1'b0, shreg: '1,
                               pend: '0, cnt: '0, grd: '0};

    st_t st_d, st_q;
    logic sclk_fall, sclk_rise;
    logic [WORD_W-1:0] packed_w;
    logic [1:0] mode_w;
    logic [CNT_W-1:0] cnt_w;

    srp_sclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_i (sclk),
        .fall_o (sclk_fall),
        .rise_o (sclk_rise)
    );

    srp_word_pack #(.RES_W(RES_W)) u_pack (
        .res_i  (res_data),
        .err_i  (res_err),
        .filt_i (cfg_filter),
        .gain_i (cfg_gain),
        .word_o (packed_w)
    );

    always_comb begin
        st_d = st_q;
        if (powerdown) begin
            st_d = ST_RST;
        end else begin
            st_d.live = 1'b1;
            if (cfg_change) begin
                st_d.mode  = M_IDLE;
                st_d.cnt   = '0;
                st_d.grd   = '0;
                st_d.shreg = '1;
            end else if (load_req) begin
                st_d.mode = M_GUARD;
                st_d.pend = packed_w;
                st_d.grd  = '0;
                st_d.cnt  = '0;
            end else begin
                unique case (st_q.mode)
                    M_GUARD: begin
                        if (st_q.grd == GRD_W'(GUARD_CYC - 1)) begin
                            st_d.mode  = M_READY;
                            st_d.shreg = st_q.pend;
                            st_d.cnt   = '0;
                        end else begin
                            st_d.grd = st_q.grd + 1'b1;
                        end
                    end
                    M_READY: begin
                        if (sclk_fall) begin
                            if (st_q.cnt == '0) begin
                                st_d.cnt = CNT_W'(1);
                            end else if (st_q.cnt < CNT_W'(WORD_W)) begin
                                st_d.shreg = {st_q.shreg[WORD_W-2:0], 1'b1};
                                st_d.cnt   = st_q.cnt + 1'b1;
                            end
                        end else if (sclk_rise && st_q.cnt == CNT_W'(WORD_W)) begin
                            st_d.mode = M_IDLE;
                            st_d.cnt  = '0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RST;
        else        st_q <= st_d;
    end

    always_comb begin
        sdo_en = st_q.live;
        if (st_q.mode == M_READY)
            sdo = (st_q.cnt == '0) ? 1'b0 : st_q.shreg[WORD_W-1];
        else
            sdo = 1'b1;
    end

    assign mode_w = st_q.mode;
    assign cnt_w  = st_q.cnt;
endmodule

// File: rtl/srp_checker.sv
module srp_checker
    import srp_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int CNT_W  = 6
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             powerdown_i,
    input logic             cfg_change_i,
    input logic             load_req_i,
    input logic             sdo_i,
    input logic             sdo_en_i,
    input logic [1:0]       mode_i,
    input logic [CNT_W-1:0] cnt_i
);
    p_tristate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        powerdown_i |=> !sdo_en_i);

    p_cfg_high_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_change_i && !powerdown_i) |=> (sdo_i && sdo_en_i));

    p_guard_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_req_i && !powerdown_i && !cfg_change_i) |=> sdo_i);

    p_ready_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == M_READY && $past(mode_i) == M_GUARD) |-> (!sdo_i && sdo_en_i));

    p_cnt_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_i <= CNT_W'(WORD_W));
endmodule

bind serial_result_port srp_checker #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_srp_chk (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .powerdown_i  (powerdown),
    .cfg_change_i (cfg_change),
    .load_req_i   (load_req),
    .sdo_i        (sdo),
    .sdo_en_i     (sdo_en),
    .mode_i       (mode_w),
    .cnt_i        (cnt_w)
);

// File: tb/test_serial_result_port.sv
module test_serial_result_port;
    localparam int GUARD = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic powerdown = 1'b0, cfg_change = 1'b0, load_req = 1'b0;
    logic [23:0] res_data = '0;
    logic res_err = 1'b0, cfg_filter = 1'b0, cfg_gain = 1'b0;
    logic sclk = 1'b1;
    logic sdo, sdo_en;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] exp_q[$];

    always #5 clk = ~clk;

    serial_result_port #(.RES_W(24), .GUARD_CYC(GUARD), .SYNC_STAGES(2)) i_serial_result_port (
        .clk(clk), .rst_n(rst_n), .powerdown(powerdown), .cfg_change(cfg_change),
        .load_req(load_req), .res_data(res_data), .res_err(res_err),
        .cfg_filter(cfg_filter), .cfg_gain(cfg_gain), .sclk(sclk),
        .sdo(sdo), .sdo_en(sdo_en)
    );

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    // driver: strobe a result and push its expected word
    task automatic post(input logic [23:0] r, input logic e, input logic f, input logic g);
        @(negedge clk);
        res_data = r; res_err = e; cfg_filter = f; cfg_gain = g; load_req = 1'b1;
        @(negedge clk);
        load_req = 1'b0;
        exp_q.push_back({r, 1'b0, f, e, 2'b01, g, 2'b01});
        wait_n(1);
        chk("R6 guard high", {31'd0, sdo}, 32'd1);
        wait_n(GUARD + 4);
        chk("R3 ready low", {30'd0, sdo_en, sdo}, 32'd2);
    endtask

    task automatic sbit(output logic b);
        sclk = 1'b0;
        wait_n(6);
        b = sdo;
        sclk = 1'b1;
        wait_n(6);
    endtask

    task automatic grab(input int pause_at, output logic [31:0] w);
        logic b;
        w = '0;
        for (int i = 31; i >= 0; i--) begin
            if (i == pause_at) wait_n(60);
            sbit(b);
            w[i] = b;
        end
    endtask

    // monitor: read one word and compare it against the scoreboard head
    task automatic read_pop(input string req, input int pause_at);
        logic [31:0] got, expv;
        grab(pause_at, got);
        expv = exp_q.pop_front();
        chk(req, got, expv);
        chk("R5 high after word", {31'd0, sdo}, 32'd1);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog R1: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] w;
        logic b;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(3);
        chk("R8 reset enable/high", {30'd0, sdo_en, sdo}, 32'd3);

        // R1 R2: formats and offset-binary extremes
        post(24'h800000, 1'b0, 1'b1, 1'b0);
        read_pop("R1 mid-scale word", -1);
        post(24'h000000, 1'b1, 1'b0, 1'b1);
        read_pop("R2 negative full scale", -1);
        post(24'hFFFFFF, 1'b1, 1'b1, 1'b1);
        read_pop("R2 positive full scale", -1);

        // R5: a second read of the same word yields ones
        grab(-1, w);
        chk("R5 read once", w, 32'hFFFFFFFF);

        // R4: pause in mid word
        post(24'h5A3C96, 1'b0, 1'b0, 1'b1);
        read_pop("R4 paused read", 13);

        // R6: partial read then overwritten by a new load
        post(24'h123456, 1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 10; i++) sbit(b);
        exp_q.delete();
        post(24'hABCDEF, 1'b1, 1'b0, 1'b0);
        read_pop("R6 overwrite restarts", -1);

        // R6: unread word replaced
        post(24'h111111, 1'b0, 1'b0, 1'b0);
        exp_q.delete();
        post(24'h222222, 1'b0, 1'b1, 1'b1);
        read_pop("R6 unread replaced", -1);

        // R6: serial edge inside guard window is ignored
        @(negedge clk);
        res_data = 24'hC0FFEE; res_err = 1'b0; cfg_filter = 1'b1; cfg_gain = 1'b0; load_req = 1'b1;
        @(negedge clk);
        load_req = 1'b0;
        sclk = 1'b0;
        @(negedge clk);
        sclk = 1'b1;
        exp_q.push_back({24'hC0FFEE, 1'b0, 1'b1, 1'b0, 2'b01, 1'b0, 2'b01});
        wait_n(GUARD + 6);
        chk("R6 edge in guard ignored, low", {31'd0, sdo}, 32'd0);
        read_pop("R6 edge in guard ignored", -1);

        // R7: settings change discards pending word
        post(24'h765432, 1'b1, 1'b1, 1'b1);
        for (int i = 0; i < 5; i++) sbit(b);
        exp_q.delete();
        @(negedge clk); cfg_change = 1'b1;
        @(negedge clk); cfg_change = 1'b0;
        wait_n(2);
        chk("R7 high after change", {31'd0, sdo}, 32'd1);
        grab(-1, w);
        chk("R7 reads all ones", w, 32'hFFFFFFFF);

        // R8: power-down tristates and clears
        post(24'h0F0F0F, 1'b0, 1'b0, 1'b0);
        exp_q.delete();
        @(negedge clk); powerdown = 1'b1;
        wait_n(3);
        chk("R8 tristate", {31'd0, sdo_en}, 32'd0);
        for (int i = 0; i < 3; i++) sbit(b);
        @(negedge clk); powerdown = 1'b0;
        wait_n(3);
        chk("R8 after release", {30'd0, sdo_en, sdo}, 32'd3);
        grab(-1, w);
        chk("R8 no word after release", w, 32'hFFFFFFFF);
        post(24'h3E8001, 1'b1, 1'b0, 1'b1);
        read_pop("R8 works after release", -1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule